// File: doc/BRIEF.md
# Processor-to-Peripheral Strobe Bridge

This block sits between a processor bus with separate active-low read and write strobes and a peripheral that also takes separate strobes. The peripheral has two demands. Its write data must already be valid when its write strobe first goes low. It also treats both of its strobes low at the same moment as a reset command. The bridge registers the processor strobes and a range-decoded chip select. It turns the processor's reset output into a simultaneous low on both peripheral strobes. As a build-time option, it holds back the leading edge of the peripheral write strobe by a set number of clock cycles.

Each output strobe is the registered AND of the processor strobe and the inverted processor reset. Either one can therefore pull the output low. A parameter chooses between two write modes. In delayed mode the write strobe falls a fixed number of edges late. In bypass mode it is handled exactly like the read strobe, for processors whose write data are valid at the strobe. In both modes the write strobe rises again on the first edge that sees the processor strobe high. Outside reset the bridge never lets both peripheral strobes be low together, so a bus glitch cannot reset the peripheral by accident.

Top module: `strb_bridge`

## Requirements
- R1: While `rst_n` is low, `per_rd_n`, `per_wr_n` and `per_ce_n` are all high, including immediately after an asynchronous assertion of `rst_n` in mid-run.
- R2: `per_ce_n` equals the value of `cpu_pcs_n` sampled at the previous rising clock edge.
- R3: With `cpu_reset` low and `cpu_wr_n` high at an edge, `per_rd_n` takes the value of `cpu_rd_n` sampled at that edge.
- R4: An edge that samples `cpu_reset` high drives both `per_rd_n` and `per_wr_n` low, whatever the processor strobes are.
- R5: In delayed mode (`WR_DELAYED`=1), if `cpu_wr_n` is sampled low (with `cpu_rd_n` high and no reset) at edge k and at every edge after it, `per_wr_n` is high after edges k to k+`WR_DELAY_CYC`-1 and low from edge k+`WR_DELAY_CYC` on. The default delay is 1.
- R6: `per_wr_n` returns high at the first edge that samples `cpu_wr_n` high, with no added hold.
- R7: In bypass mode (`WR_DELAYED`=0), `per_wr_n` takes the value of `cpu_wr_n` sampled at the previous edge, the same way the read path works.
- R8: An edge that samples both `cpu_rd_n` and `cpu_wr_n` low with `cpu_reset` low drives both output strobes high. The write delay count keeps running through such an overlap, so a write that remains after the read is released asserts as soon as its count allows.
- R9: In delayed mode, a processor write strobe that is sampled low on fewer than `WR_DELAY_CYC` consecutive edges produces no low on `per_wr_n`.
- R10: An edge that samples `cpu_reset` high clears the write delay count. A write held low through reset waits the full `WR_DELAY_CYC` edges after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_pcs_n | input | 1 | Range-decoded peripheral select from the processor, active low |
| cpu_reset | input | 1 | Processor reset output, active high |
| per_rd_n | output | 1 | Peripheral read strobe, active low, registered |
| per_wr_n | output | 1 | Peripheral write strobe, active low, registered |
| per_ce_n | output | 1 | Peripheral chip enable, active low, registered |

## Verification
The bridge is driven with three kinds of pattern. Isolated read and write strobes show the one-edge read path, and show that the delayed write differs from the bypass write by exactly the set delay. Short write pulses and writes that run across a processor reset tell a counter that saturates and clears correctly from one that leaks or keeps stale counts. Overlapping read and write strobes, with and without reset, separate the protective both-high response from the intended both-low reset command. A long randomised stream with sticky strobes and rare resets then compares every output on every cycle against a bench model, for both a three-cycle delayed instance and a bypass instance.

// File: rtl/strb_pkg.sv
`timescale 1ns/1ps
package strb_pkg;

  // Bus action chosen for the next clock edge
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_RESET = 2'd3
  } bus_cmd_e;

  // Peripheral strobe pair, both active low
  typedef struct packed {
    logic rd_n;
    logic wr_n;
  } strobe_pair_t;

  localparam strobe_pair_t STROBES_IDLE = '{rd_n: 1'b1, wr_n: 1'b1};

endpackage

// File: rtl/strb_rst_sync.sv
`timescale 1ns/1ps
module strb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/strb_wr_gate.sv
`timescale 1ns/1ps
module strb_wr_gate #(
  parameter bit WR_DELAYED   = 1'b1,
  parameter int WR_DELAY_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_low,
  input  logic clr,
  output logic wr_ready
);

  localparam int CNT_W = $clog2(WR_DELAY_CYC + 2);
  localparam bit USE_CNT = WR_DELAYED && (WR_DELAY_CYC > 0);

  generate
    if (USE_CNT) begin : g_delay
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WR_DELAY_CYC);

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;
      logic             cnt_en;
      logic             at_limit;

      assign at_limit = (cnt_q == LIMIT);

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (clr || !wr_low) begin
          cnt_en = (cnt_q != '0);
          cnt_d  = '0;
        end else if (!at_limit) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + CNT_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (cnt_en) begin
          cnt_q <= cnt_d;
        end
      end

      assign wr_ready = wr_low && at_limit;
    end else begin : g_bypass
      logic unused_bypass;
      assign unused_bypass = ^{clk, rst_n, clr};
      assign wr_ready      = wr_low;
    end
  endgenerate

endmodule

// File: rtl/strb_arbiter.sv
`timescale 1ns/1ps
module strb_arbiter
  import strb_pkg::*;
(
  input  logic     rd_low,
  input  logic     wr_low,
  input  logic     wr_ready,
  input  logic     cpu_reset,
  output bus_cmd_e cmd
);

  always_comb begin
    if (cpu_reset) begin
      cmd = CMD_RESET;
    end else if (rd_low && wr_low) begin
      cmd = CMD_IDLE;
    end else if (rd_low) begin
      cmd = CMD_READ;
    end else if (wr_ready) begin
      cmd = CMD_WRITE;
    end else begin
      cmd = CMD_IDLE;
    end
  end

endmodule

// File: rtl/strb_out_reg.sv
`timescale 1ns/1ps
module strb_out_reg
  import strb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_cmd_e cmd,
  input  logic     pcs_n,
  output logic     per_rd_n,
  output logic     per_wr_n,
  output logic     per_ce_n
);

  strobe_pair_t stb_q;
  strobe_pair_t stb_d;
  logic         ce_q;
  logic         ce_d;
  logic         upd_en;

  assign upd_en = 1'b1;

  always_comb begin
    stb_d = STROBES_IDLE;
    unique case (cmd)
      CMD_READ:  stb_d.rd_n = 1'b0;
      CMD_WRITE: stb_d.wr_n = 1'b0;
      CMD_RESET: stb_d      = '{rd_n: 1'b0, wr_n: 1'b0};
      default:   stb_d      = STROBES_IDLE;
    endcase
    ce_d = pcs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= STROBES_IDLE;
      ce_q  <= 1'b1;
    end else if (upd_en) begin
      stb_q <= stb_d;
      ce_q  <= ce_d;
    end
  end

  assign per_rd_n = stb_q.rd_n;
  assign per_wr_n = stb_q.wr_n;
  assign per_ce_n = ce_q;

endmodule

// File: rtl/strb_bridge.sv
`timescale 1ns/1ps
module strb_bridge
  import strb_pkg::*;
#(
  parameter bit WR_DELAYED   = 1'b1,
  parameter int WR_DELAY_CYC = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_rd_n,
  input  logic cpu_wr_n,
  input  logic cpu_pcs_n,
  input  logic cpu_reset,
  output logic per_rd_n,
  output logic per_wr_n,
  output logic per_ce_n
);

  logic     rst_sync_n;
  logic     rd_low;
  logic     wr_low;
  logic     wr_ready;
  bus_cmd_e cmd;

  assign rd_low = ~cpu_rd_n;
  assign wr_low = ~cpu_wr_n;

  strb_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  strb_wr_gate #(
    .WR_DELAYED   (WR_DELAYED),
    .WR_DELAY_CYC (WR_DELAY_CYC)
  ) u_wr_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_low   (wr_low),
    .clr      (cpu_reset),
    .wr_ready (wr_ready)
  );

  strb_arbiter u_arb (
    .rd_low    (rd_low),
    .wr_low    (wr_low),
    .wr_ready  (wr_ready),
    .cpu_reset (cpu_reset),
    .cmd       (cmd)
  );

  strb_out_reg u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd      (cmd),
    .pcs_n    (cpu_pcs_n),
    .per_rd_n (per_rd_n),
    .per_wr_n (per_wr_n),
    .per_ce_n (per_ce_n)
  );

endmodule

// File: rtl/strb_bridge_chk.sv
`timescale 1ns/1ps
module strb_bridge_chk (
  input logic clk,
  input logic rst_ok,
  input logic cpu_rd_n,
  input logic cpu_wr_n,
  input logic cpu_pcs_n,
  input logic cpu_reset,
  input logic per_rd_n,
  input logic per_wr_n,
  input logic per_ce_n
);

  // R2: chip enable is the select delayed by one edge
  p_ce_follow_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> (per_ce_n == $past(cpu_pcs_n)));

  // R3: read path with no write and no reset
  p_rd_follow_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(cpu_reset) && $past(cpu_wr_n))
      |-> (per_rd_n == $past(cpu_rd_n)));

  // R4: processor reset drives both strobes low
  p_reset_both_low_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cpu_reset)) |-> (!per_rd_n && !per_wr_n));

  // R5: a low write output always has a low processor strobe behind it
  p_wr_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !per_wr_n) |-> (!$past(cpu_wr_n) || $past(cpu_reset)));

  // R6: write output released on the first high sample
  p_wr_release_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(cpu_wr_n) && !$past(cpu_reset)) |-> per_wr_n);

  // R8: never both low outside processor reset
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && !$past(cpu_reset)) |-> (per_rd_n || per_wr_n));

endmodule

bind strb_bridge strb_bridge_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cpu_rd_n  (cpu_rd_n),
  .cpu_wr_n  (cpu_wr_n),
  .cpu_pcs_n (cpu_pcs_n),
  .cpu_reset (cpu_reset),
  .per_rd_n  (per_rd_n),
  .per_wr_n  (per_wr_n),
  .per_ce_n  (per_ce_n)
);

// File: tb/strb_bridge_tb.sv
`timescale 1ns/1ps
module strb_bridge_tb;

  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd_n = 1'b1;
  logic cpu_wr_n = 1'b1;
  logic cpu_pcs_n = 1'b1;
  logic cpu_reset = 1'b0;
  logic d_rd, d_wr, d_ce, b_rd, b_wr, b_ce;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  strb_bridge #(.WR_DELAYED(1'b1), .WR_DELAY_CYC(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_pcs_n(cpu_pcs_n), .cpu_reset(cpu_reset),
    .per_rd_n(d_rd), .per_wr_n(d_wr), .per_ce_n(d_ce));

  strb_bridge #(.WR_DELAYED(1'b0), .WR_DELAY_CYC(DLY)) u_byp (
    .clk(clk), .rst_n(rst_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_pcs_n(cpu_pcs_n), .cpu_reset(cpu_reset),
    .per_rd_n(b_rd), .per_wr_n(b_wr), .per_ce_n(b_ce));

  // Expected strobes {rd_n, wr_n} from the requirements
  function automatic logic [1:0] f_strobes(input logic rd_low, input logic wr_low,
                                           input logic rst, input logic ready);
    if (rst) return 2'b00;
    if (rd_low && wr_low) return 2'b11;
    if (rd_low) return 2'b01;
    if (ready) return 2'b10;
    return 2'b11;
  endfunction

  function automatic int f_cnt(input int c, input logic wr_low, input logic rst, input int lim);
    if (rst || !wr_low) return 0;
    return (c < lim) ? c + 1 : c;
  endfunction

  logic e_rd_d, e_wr_d, e_rd_b, e_wr_b, e_ce;
  int   cnt_d;
  logic l_rdl, l_wrl, l_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rd_d <= 1'b1; e_wr_d <= 1'b1; e_rd_b <= 1'b1; e_wr_b <= 1'b1; e_ce <= 1'b1;
      cnt_d <= 0; l_rdl <= 1'b0; l_wrl <= 1'b0; l_rst <= 1'b0;
    end else begin
      {e_rd_d, e_wr_d} <= f_strobes(!cpu_rd_n, !cpu_wr_n, cpu_reset,
                                    (!cpu_wr_n) && (cnt_d >= DLY));
      {e_rd_b, e_wr_b} <= f_strobes(!cpu_rd_n, !cpu_wr_n, cpu_reset, !cpu_wr_n);
      e_ce  <= cpu_pcs_n;
      cnt_d <= f_cnt(cnt_d, !cpu_wr_n, cpu_reset, DLY);
      l_rdl <= !cpu_rd_n; l_wrl <= !cpu_wr_n; l_rst <= cpu_reset;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string rq;
    string wq;
    rq = l_rst ? "R4" : ((l_rdl && l_wrl) ? "R8" : "R3");
    wq = l_rst ? "R4" : ((l_rdl && l_wrl) ? "R8" : "R5");
    chk(rq, "dly per_rd_n", d_rd, e_rd_d);
    chk(wq, "dly per_wr_n", d_wr, e_wr_d);
    chk(rq, "byp per_rd_n", b_rd, e_rd_b);
    chk(l_rst ? "R4" : "R7", "byp per_wr_n", b_wr, e_wr_b);
    chk("R2", "dly per_ce_n", d_ce, e_ce);
    chk("R2", "byp per_ce_n", b_ce, e_ce);
  endtask

  // One cycle: check at the falling edge, then drive new inputs
  task automatic step(input logic rd, input logic wr, input logic pcs, input logic rst);
    @(negedge clk);
    compare_all();
    cpu_rd_n = rd; cpu_wr_n = wr; cpu_pcs_n = pcs; cpu_reset = rst;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R1: outputs idle while held in reset
    chk("R1", "per_rd_n in reset", d_rd, 1'b1);
    chk("R1", "per_wr_n in reset", d_wr, 1'b1);
    chk("R1", "per_ce_n in reset", d_ce, 1'b1);
    rst_n = 1'b1;
    repeat (4) step(1, 1, 1, 0);

    // R5 / R7: write delay against bypass
    step(1, 1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0); chk("R7", "byp wr after 1 edge", b_wr, 1'b0);
                      chk("R5", "dly wr after 1 edge", d_wr, 1'b1);
    step(1, 0, 0, 0); chk("R5", "dly wr after 2 edges", d_wr, 1'b1);
    step(1, 0, 0, 0); chk("R5", "dly wr after 3 edges", d_wr, 1'b1);
    step(1, 1, 0, 0); chk("R5", "dly wr after 4 edges", d_wr, 1'b0);
    step(1, 1, 0, 0); chk("R6", "dly wr released", d_wr, 1'b1);
                      chk("R6", "byp wr released", b_wr, 1'b1);

    // R9: short write pulse never reaches the peripheral
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0); chk("R9", "short pulse edge 1", d_wr, 1'b1);
    step(1, 1, 1, 0); chk("R9", "short pulse edge 2", d_wr, 1'b1);
    step(1, 1, 1, 0); chk("R9", "short pulse after", d_wr, 1'b1);

    // R10 / R4: write held through processor reset restarts its delay
    step(1, 0, 0, 0);
    step(1, 0, 0, 1);
    step(1, 0, 0, 1);
    step(1, 0, 0, 0); chk("R4", "reset rd low", d_rd, 1'b0);
                      chk("R4", "reset wr low", d_wr, 1'b0);
    step(1, 0, 0, 0); chk("R10", "after reset edge 1", d_wr, 1'b1);
    step(1, 0, 0, 0); chk("R10", "after reset edge 2", d_wr, 1'b1);
    step(1, 0, 0, 0); chk("R10", "after reset edge 3", d_wr, 1'b1);
    step(1, 1, 1, 0); chk("R10", "after reset edge 4", d_wr, 1'b0);
    step(1, 1, 1, 0);

    // R8: overlapping strobes outside reset
    step(0, 1, 0, 0);
    step(0, 0, 0, 0); chk("R3", "byp read asserted", b_rd, 1'b0);
    step(1, 0, 0, 0); chk("R8", "overlap dly rd", d_rd, 1'b1);
                      chk("R8", "overlap dly wr", d_wr, 1'b1);
                      chk("R8", "overlap byp rd", b_rd, 1'b1);
                      chk("R8", "overlap byp wr", b_wr, 1'b1);
    step(1, 0, 0, 0); chk("R8", "byp write after overlap", b_wr, 1'b0);
    step(1, 1, 1, 0);
    step(1, 1, 1, 0);

    // R2: chip enable follows select
    step(1, 1, 0, 0);
    step(1, 1, 1, 0); chk("R2", "ce low", d_ce, 1'b0);
    step(1, 1, 1, 0); chk("R2", "ce high", d_ce, 1'b1);

    // R1: asynchronous reset in mid-run
    step(1, 0, 0, 0);
    repeat (5) step(1, 0, 0, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1", "async rst per_wr_n", d_wr, 1'b1);
    chk("R1", "async rst per_ce_n", d_ce, 1'b1);
    cpu_rd_n = 1'b1; cpu_wr_n = 1'b1; cpu_pcs_n = 1'b1; cpu_reset = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1, 1, 1, 0);

    // Random stream with sticky strobes and rare processor resets
    begin
      logic rd, wr, rst;
      rd = 1'b1; wr = 1'b1; rst = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        r = $urandom;
        if (r[1:0] == 2'd0) rd = ~rd;
        if (r[3:2] == 2'd0) wr = ~wr;
        if (rst) rst = (r[7:5] != 3'd0);
        else     rst = (r[13:8] == 6'd0);
        step(rd, wr, r[4], rst);
      end
    end
    step(1, 1, 1, 0);
    step(1, 1, 1, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule